// File: doc/BRIEF.md
# Byte-FIFO SPI Master with Register Interface

This block is a word-addressed SPI master. Software queues bytes through a transmit data register into a transmit FIFO. While the inhibit bit in the control register is clear, a mode-0 shift engine takes one queued byte at a time and shifts it out MSB first. The byte that arrives on `miso_i` during that transfer is pushed into a receive FIFO. Software drains the receive FIFO through a receive data register.

The register file also provides a read-only status word and two occupancy counters. It has a slave-select register that drives active-low select lines, and a soft reset that acts only when written with a fixed key value. Single-cycle event pulses report completed bytes, FIFO transitions and dropped receive bytes to a separate interrupt block. Reads are combinational: `rdata_o` is valid in the same cycle as `req_i`, and a receive pop takes effect at the clock edge that ends the access.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, status reads 0x5, control reads 0, every `ss_no` line is high, both occupancy registers read 0 and `sclk_o` is low.
- R2: Transfers use SPI mode 0, MSB first. `sclk_o` idles low and has a period of `SCK_DIV` clock cycles. `mosi_o` changes only while `sclk_o` is low. `miso_i` is sampled on each rising edge of `sclk_o`.
- R3: A write to offset 0x68 queues bits 7:0 of the write data and ignores the upper bits. Queued bytes are sent in order, and each received byte is stored in the receive FIFO.
- R4: While control bit 8 is set, no transfer starts and `sclk_o` stays low. Clearing bit 8 with bytes queued drains the transmit FIFO.
- R5: In the control register (offset 0x60), bit 5 empties the transmit FIFO and bit 6 empties the receive FIFO. Both bits act once and read back as 0. The other control bits are stored and read back.
- R6: The status register (offset 0x64) has bit 3 transmit full, bit 2 transmit empty, bit 1 receive full and bit 0 receive empty. Writes to it have no effect.
- R7: The occupancy registers (0x74 transmit, 0x78 receive) read the entry count minus one, and read 0 when the FIFO is empty.
- R8: A read of offset 0x6C returns the oldest receive byte, zero-extended, and removes it. If the receive FIFO is empty, the read returns 0xDEADBEEF and changes nothing.
- R9: A byte that completes while the receive FIFO is full is discarded. `evt_overrun_o` pulses for one cycle, and the FIFO contents are left unchanged.
- R10: Writing 0x0000000A to offset 0x40 clears control, empties both FIFOs and sets the select register to all ones. Any other value written there has no effect.
- R11: `ss_no[i]` equals bit i of the select register (offset 0x70), and a select is active when its bit is 0.
- R12: An access with `addr_i[1:0]` nonzero is ignored and reads 0. A transmit write while the transmit FIFO is full is dropped.
- R13: `evt_tx_done_o` pulses once per completed byte, and `evt_rx_done_o` once per stored byte. `evt_tx_empty_o` pulses when the engine takes the last queued byte, and `evt_rx_full_o` when a push fills the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as `req_i` |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | NUM_SS | Active-low slave selects |
| evt_tx_done_o | output | 1 | Byte shifted out |
| evt_rx_done_o | output | 1 | Received byte stored |
| evt_rx_full_o | output | 1 | Receive FIFO became full |
| evt_tx_empty_o | output | 1 | Transmit FIFO became empty |
| evt_overrun_o | output | 1 | Received byte dropped |

## Verification
The bench fills the receive FIFO to its full 256 entries and then sends one more byte. A design with a wrong full test would either overwrite the oldest entry or wrap the count back to zero, and the bench would see the occupancy or the first byte read change. It reads the empty receive FIFO and expects the sentinel with no change to state; a design that popped anyway would corrupt the pointers and report a nonzero occupancy. It sends keys that are close to the soft-reset value but wrong, writes misaligned addresses and sets the one-shot FIFO reset bits. A loose decode would clear the selects or leave bits 5 and 6 stored in the control register. Loopback with and without inversion, together with a capture of `mosi_o` on each rising `sclk_o`, exposes bit-order reversal, sampling on the wrong edge and a wrong clock divisor.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned REG_AW = 7;
  localparam logic [REG_AW-1:0] OFS_SRST  = 7'h40;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 7'h60;
  localparam logic [REG_AW-1:0] OFS_STAT  = 7'h64;
  localparam logic [REG_AW-1:0] OFS_TXD   = 7'h68;
  localparam logic [REG_AW-1:0] OFS_RXD   = 7'h6C;
  localparam logic [REG_AW-1:0] OFS_SSEL  = 7'h70;
  localparam logic [REG_AW-1:0] OFS_TXOCC = 7'h74;
  localparam logic [REG_AW-1:0] OFS_RXOCC = 7'h78;
  localparam logic [31:0] SRST_KEY     = 32'h0000_000A;
  localparam logic [31:0] EMPTY_WORD   = 32'hDEAD_BEEF;
  localparam int unsigned CTRL_TXCLR   = 5;
  localparam int unsigned CTRL_RXCLR   = 6;
  localparam int unsigned CTRL_INHIBIT = 8;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    data_i,
  input  logic          pop_i,
  output logic [7:0]    data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign data_o  = mem[rd_ptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  a_r12_full_push_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o);
  a_r8_empty_pop_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned SCK_DIV = 4,
  localparam int unsigned HALF = SCK_DIV / 2,
  localparam int unsigned HCW  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  logic           busy_q, sclk_q, done_q;
  logic [HCW-1:0] div_q;
  logic [2:0]     bit_q;
  logic [7:0]     tx_sr, rx_sr;
  logic           phase_end;

  assign phase_end = (div_q == HCW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        sclk_q <= 1'b0;
      end else if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        div_q  <= '0;
        bit_q  <= '0;
        tx_sr  <= data_i;
      end else if (busy_q) begin
        if (!phase_end) begin
          div_q <= div_q + 1'b1;
        end else begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sr  <= {rx_sr[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_sr <= {tx_sr[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_sr[7];
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_sr;

  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  a_r2_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  a_r13_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 256,
  parameter int unsigned NUM_SS     = 1,
  parameter int unsigned SCK_DIV    = 4,
  parameter int unsigned ADDR_W     = REG_AW,
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  output logic              evt_tx_done_o,
  output logic              evt_rx_done_o,
  output logic              evt_rx_full_o,
  output logic              evt_tx_empty_o,
  output logic              evt_overrun_o
);
  logic [31:0]       ctrl_q;
  logic [NUM_SS-1:0] ssel_q;
  logic              acc_ok, wr, rd, soft_rst;
  logic              tx_clr, rx_clr, tx_push, rx_push, rx_pop, eng_start;
  logic [7:0]        tx_head, rx_head, eng_rx;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              eng_busy, eng_done;

  assign acc_ok   = req_i && (addr_i[1:0] == 2'b00);
  assign wr       = acc_ok && we_i;
  assign rd       = acc_ok && !we_i;
  assign soft_rst = wr && (addr_i == OFS_SRST) && (wdata_i == SRST_KEY);
  assign tx_clr   = soft_rst || (wr && (addr_i == OFS_CTRL) && wdata_i[CTRL_TXCLR]);
  assign rx_clr   = soft_rst || (wr && (addr_i == OFS_CTRL) && wdata_i[CTRL_RXCLR]);
  assign tx_push  = wr && (addr_i == OFS_TXD);
  assign rx_pop   = rd && (addr_i == OFS_RXD) && !rx_empty;
  assign eng_start = !eng_busy && !tx_empty && !ctrl_q[CTRL_INHIBIT] && !tx_clr;
  assign rx_push  = eng_done && !rx_full && !rx_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ssel_q <= '1;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      ssel_q <= '1;
    end else if (wr) begin
      if (addr_i == OFS_CTRL)
        ctrl_q <= wdata_i & ~((32'd1 << CTRL_TXCLR) | (32'd1 << CTRL_RXCLR));
      if (addr_i == OFS_SSEL)
        ssel_q <= wdata_i[NUM_SS-1:0];
    end
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr), .push_i(tx_push), .data_i(wdata_i[7:0]),
    .pop_i(eng_start), .data_o(tx_head), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty));

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr), .push_i(rx_push), .data_i(eng_rx),
    .pop_i(rx_pop), .data_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty));

  spi_shift_engine #(.SCK_DIV(SCK_DIV)) u_engine (
    .clk_i, .rst_ni, .abort_i(soft_rst), .start_i(eng_start), .data_i(tx_head),
    .miso_i, .sclk_o, .mosi_o, .busy_o(eng_busy), .done_o(eng_done),
    .rx_byte_o(eng_rx));

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_CTRL:  rdata_o = ctrl_q;
        OFS_STAT:  rdata_o = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
        OFS_RXD:   rdata_o = rx_empty ? EMPTY_WORD : {24'd0, rx_head};
        OFS_SSEL:  rdata_o = 32'(ssel_q);
        OFS_TXOCC: rdata_o = tx_empty ? 32'd0 : 32'(tx_cnt - 1'b1);
        OFS_RXOCC: rdata_o = rx_empty ? 32'd0 : 32'(rx_cnt - 1'b1);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ss_no          = ssel_q;
  assign evt_tx_done_o  = eng_done;
  assign evt_rx_done_o  = rx_push;
  assign evt_overrun_o  = eng_done && rx_full && !rx_clr;
  assign evt_tx_empty_o = eng_start && (tx_cnt == CW'(1)) && !tx_push;
  assign evt_rx_full_o  = rx_push && !rx_pop && (rx_cnt == CW'(FIFO_DEPTH - 1));

  a_r10_srst_sets_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ss_no == '1));
  a_r8_empty_read_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_RXD && rx_empty && !eng_done) |=> (rx_cnt == '0));
  a_r9_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_overrun_o && !rx_pop) |=> $stable(rx_cnt));
  a_r4_inhibit_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_INHIBIT] && !eng_busy) |=> !sclk_o);
endmodule

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  localparam int unsigned DEPTH = 256;
  localparam int unsigned NSS   = 2;
  localparam int unsigned DIV   = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sclk_o, mosi_o, miso_i;
  logic [NSS-1:0] ss_no;
  logic        evt_tx_done_o, evt_rx_done_o, evt_rx_full_o, evt_tx_empty_o, evt_overrun_o;
  logic        invert = 1'b0;

  int checks = 0, errors = 0;
  int n_txd = 0, n_rxd = 0, n_rxf = 0, n_txe = 0, n_ovr = 0, n_rise = 0;
  longint cyc = 0, last_rise = 0, rise_gap = 0;
  logic [7:0] slave_sr = '0;
  logic [31:0] rv;

  always #2 clk_i = ~clk_i;
  assign miso_i = invert ? ~mosi_o : mosi_o;

  spi_fifo_master #(.FIFO_DEPTH(DEPTH), .NUM_SS(NSS), .SCK_DIV(DIV)) u_spi_fifo_master (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .sclk_o, .mosi_o,
    .miso_i, .ss_no, .evt_tx_done_o, .evt_rx_done_o, .evt_rx_full_o,
    .evt_tx_empty_o, .evt_overrun_o);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni) begin
      n_txd <= n_txd + int'(evt_tx_done_o);
      n_rxd <= n_rxd + int'(evt_rx_done_o);
      n_rxf <= n_rxf + int'(evt_rx_full_o);
      n_txe <= n_txe + int'(evt_tx_empty_o);
      n_ovr <= n_ovr + int'(evt_overrun_o);
    end
  end

  always @(posedge sclk_o) begin
    slave_sr  <= {slave_sr[6:0], mosi_o};
    rise_gap  <= cyc - last_rise;
    last_rise <= cyc;
    n_rise    <= n_rise + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drain_wait(input int bytes);
    idle(bytes * (8 * DIV + 4) + 10);
  endtask

  task automatic t_reset;
    rd(7'h64, rv); check(rv == 32'h5, "R1 status", rv, 32'h5);
    rd(7'h60, rv); check(rv == 0, "R1 control", rv, 0);
    rd(7'h74, rv); check(rv == 0, "R1 tx occupancy", rv, 0);
    rd(7'h78, rv); check(rv == 0, "R1 rx occupancy", rv, 0);
    check(ss_no == 2'b11 && sclk_o == 1'b0, "R1 ss/sclk", {ss_no, sclk_o}, 3'b110);
  endtask

  task automatic t_select;
    wr(7'h70, 32'h2);
    check(ss_no == 2'b10, "R11 select 0 active", ss_no, 2'b10);
    rd(7'h70, rv); check(rv == 32'h2, "R11 readback", rv, 2);
    wr(7'h72, 32'h0);
    check(ss_no == 2'b10, "R12 misaligned write ignored", ss_no, 2'b10);
    rd(7'h65, rv); check(rv == 0, "R12 misaligned read zero", rv, 0);
  endtask

  task automatic t_basic;
    invert = 1'b0;
    wr(7'h68, 32'hFFFF_FFA5);
    drain_wait(1);
    check(slave_sr == 8'hA5, "R2 MSB-first on mosi", slave_sr, 8'hA5);
    check(rise_gap == DIV, "R2 sclk period", rise_gap, DIV);
    check(sclk_o == 1'b0, "R2 idle low", sclk_o, 0);
    rd(7'h6C, rv); check(rv == 32'hA5, "R3 loopback byte, upper bits dropped", rv, 32'hA5);
    invert = 1'b1;
    wr(7'h68, 32'h3C);
    drain_wait(1);
    rd(7'h6C, rv); check(rv == 32'hC3, "R2 miso sampled", rv, 32'hC3);
    invert = 1'b0;
    check(n_txd == 2 && n_rxd == 2, "R13 done pulses", n_txd * 16 + n_rxd, 34);
  endtask

  task automatic t_inhibit;
    int r0;
    wr(7'h60, 32'h100);
    r0 = n_rise;
    wr(7'h68, 32'h11); wr(7'h68, 32'h22); wr(7'h68, 32'h33);
    idle(200);
    check(n_rise == r0, "R4 no clock while inhibited", n_rise - r0, 0);
    rd(7'h74, rv); check(rv == 2, "R7 tx occupancy", rv, 2);
    rd(7'h64, rv); check(rv == 32'h1, "R6 status pending", rv, 1);
    r0 = n_txe;
    wr(7'h60, 32'h0);
    drain_wait(3);
    check(n_txe == r0 + 1, "R13 tx empty pulse", n_txe - r0, 1);
    rd(7'h78, rv); check(rv == 2, "R7 rx occupancy", rv, 2);
    rd(7'h6C, rv); check(rv == 32'h11, "R3 order 1", rv, 32'h11);
    rd(7'h6C, rv); check(rv == 32'h22, "R3 order 2", rv, 32'h22);
    rd(7'h6C, rv); check(rv == 32'h33, "R3 order 3", rv, 32'h33);
  endtask

  task automatic t_empty_read;
    rd(7'h6C, rv); check(rv == 32'hDEADBEEF, "R8 sentinel", rv, 32'hDEADBEEF);
    rd(7'h78, rv); check(rv == 0, "R8 no state change", rv, 0);
    rd(7'h64, rv); check(rv == 32'h5, "R8 status unchanged", rv, 5);
  endtask

  task automatic t_fifo_clear;
    wr(7'h68, 32'h44); wr(7'h68, 32'h55);
    drain_wait(2);
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h66); wr(7'h68, 32'h77);
    wr(7'h60, 32'h120);
    rd(7'h64, rv); check(rv == 32'h4, "R5 tx cleared, rx kept", rv, 4);
    rd(7'h60, rv); check(rv == 32'h100, "R5 pulse bits read zero", rv, 32'h100);
    wr(7'h60, 32'h140);
    rd(7'h64, rv); check(rv == 32'h5, "R5 rx cleared", rv, 5);
    wr(7'h64, 32'h0);
    rd(7'h64, rv); check(rv == 32'h5, "R6 status write ignored", rv, 5);
    wr(7'h60, 32'h0);
  endtask

  task automatic t_soft_reset;
    wr(7'h70, 32'h0);
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h12);
    wr(7'h40, 32'h0000_000B);
    check(ss_no == 2'b00, "R10 wrong key ignored", ss_no, 0);
    rd(7'h60, rv); check(rv == 32'h100, "R10 wrong key control kept", rv, 32'h100);
    wr(7'h40, 32'h1000_000A);
    rd(7'h74, rv); check(rv == 0 && ss_no == 2'b00, "R10 near key ignored", rv, 0);
    rd(7'h64, rv); check(rv == 32'h1, "R10 near key tx kept", rv, 1);
    wr(7'h40, 32'hA);
    check(ss_no == 2'b11, "R10 selects set", ss_no, 2'b11);
    rd(7'h60, rv); check(rv == 0, "R10 control cleared", rv, 0);
    rd(7'h64, rv); check(rv == 32'h5, "R10 fifos emptied", rv, 5);
  endtask

  task automatic t_overrun;
    int bad = 0, f0, o0, t0;
    wr(7'h60, 32'h100);
    for (int i = 0; i < DEPTH; i++) wr(7'h68, i);
    rd(7'h64, rv); check(rv == 32'h9, "R6 tx full", rv, 9);
    wr(7'h68, 32'hEE);
    rd(7'h74, rv); check(rv == DEPTH - 1, "R12 push on full dropped", rv, DEPTH - 1);
    f0 = n_rxf;
    wr(7'h60, 32'h0);
    drain_wait(DEPTH);
    rd(7'h64, rv); check(rv == 32'h6, "R6 rx full, tx empty", rv, 6);
    check(n_rxf == f0 + 1, "R13 rx full pulse", n_rxf - f0, 1);
    o0 = n_ovr; t0 = n_txd;
    wr(7'h68, 32'h77);
    drain_wait(1);
    check(n_ovr == o0 + 1 && n_txd == t0 + 1, "R9 overrun pulse", n_ovr - o0, 1);
    rd(7'h78, rv); check(rv == DEPTH - 1, "R9 occupancy kept", rv, DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(7'h6C, rv);
      if (rv != i) bad++;
    end
    check(bad == 0, "R9 contents intact", bad, 0);
    rd(7'h6C, rv); check(rv == 32'hDEADBEEF, "R9 dropped byte absent", rv, 32'hDEADBEEF);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset;
    t_select;
    t_basic;
    t_inhibit;
    t_empty_read;
    t_fifo_clear;
    t_soft_reset;
    t_overrun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule